// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple single-cycle register port and manages a small array of one-time-programmable fuse words, modelled in flops. Software reads fuse contents through shadow registers. To refresh the shadows it raises a bank-open bit. The controller waits a short time, raises BUSY, and copies every fuse word into its shadow when the load ends.

To burn bits, software first writes the control register with a fuse word address and an unlock key. A write to the data register then supplies a bit mask and starts a timed program operation. Each program operation needs a fresh unlock. Any rejected request raises a sticky error flag, which only a write to the clear alias removes.

The fuse array holds banks of eight words each. A fuse word address is formed as bank times eight plus word. Both the shadow-load latency and the program duration are counted in clock cycles and set by parameters.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control register (byte offset 0x000), the data register (offset 0x010) and every shadow register read as zero, and BUSY is low.
- R2: The control register layout is: fuse address in bits 5:0, BUSY in bit 8 (read-only), ERROR in bit 9, bank-open in bit 12, and the unlock key in bits 31:16. A write to offset 0x000 loads the address, bank-open and key fields. A write to the set alias at 0x004 ORs the written bits into those fields. A write to the clear alias at 0x008 clears the written bits in those fields and in ERROR. No write can set BUSY.
- R3: A write that raises bank-open while the controller is idle keeps BUSY low for LOAD_DELAY cycles after the write. BUSY is then high for exactly LOAD_CYCLES cycles.
- R4: Shadow register n is read at offset 0x100 + 16·n, for n from 0 to NUM_BANKS·8−1. Shadows change only at the clock edge that ends a load, and they then hold a copy of every fuse word. Reads of any other offset, or of an unaligned offset in the shadow window, return zero.
- R5: A program operation starts when the data register is written while the control register holds the key 0x5A3C in bits 31:16. BUSY is high for exactly PROG_CYCLES cycles, starting in the cycle after the data write.
- R6: Programming only turns fuse bits from 0 to 1. The stored word becomes the old word OR the mask.
- R7: The key is consumed: any data write made while the key is valid clears the key field and stores the mask in the data register. A data write made without the valid key changes nothing: no BUSY, no ERROR, no change to the data register or the key field.
- R8: A keyed data write is rejected, and ERROR is set, in any of these cases: BUSY is high or a load is pending; bank-open is set; or the fuse address is NUM_BANKS·8 or above. A rejected write leaves the fuse array unchanged.
- R9: ERROR stays set through plain writes and set-alias writes. It is cleared only by a clear-alias write with bit 9 set.
- R10: A word programmed at address bank·8+word appears in the shadow register at offset 0x100 + 16·(bank·8+word) after the next load. This includes the last word, bank 4 word 7 at offset 0x370.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe; a write takes effect only when this is high |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the block with LOAD_DELAY=3, LOAD_CYCLES=5 and PROG_CYCLES=6. These short windows let every cycle of the late BUSY rise, of the load and of the program pulse be read back and compared one by one. The default array size of five banks is kept, so the last valid word (39) and the first invalid address (40) can both be reached. This covers the edge of the shadow window and the error path for an out-of-range address.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned FADDR_W = 6;

    // control register field positions
    localparam int unsigned CTL_BUSY_BIT = 8;
    localparam int unsigned CTL_ERR_BIT  = 9;
    localparam int unsigned CTL_OPEN_BIT = 12;
    localparam int unsigned CTL_KEY_LSB  = 16;

    // register offsets
    localparam int unsigned OFS_CTRL     = 'h000;
    localparam int unsigned OFS_CTRL_SET = 'h004;
    localparam int unsigned OFS_CTRL_CLR = 'h008;
    localparam int unsigned OFS_DATA     = 'h010;
    localparam int unsigned OFS_SHADOW   = 'h100;
    localparam int unsigned SHADOW_SHIFT = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_LOAD,
        SEQ_PROG
    } seq_state_e;

endpackage

// File: rtl/otp_seq.sv
module otp_seq
    import otp_pkg::*;
#(
    parameter int unsigned LOAD_DELAY  = 4,
    parameter int unsigned LOAD_CYCLES = 40,
    parameter int unsigned PROG_CYCLES = 200,
    parameter int unsigned MASK_W      = 32,
    parameter int unsigned ADR_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_load_i,
    input  logic              start_prog_i,
    input  logic [ADR_W-1:0]  prog_addr_i,
    input  logic [MASK_W-1:0] prog_mask_i,
    output logic              idle_o,
    output logic              busy_o,
    output logic              copy_o,
    output logic              prog_we_o,
    output logic [ADR_W-1:0]  we_addr_o,
    output logic [MASK_W-1:0] we_mask_o
);

    localparam int unsigned MAX_LD  = (LOAD_DELAY > LOAD_CYCLES) ? LOAD_DELAY : LOAD_CYCLES;
    localparam int unsigned CNT_MAX = (MAX_LD > PROG_CYCLES) ? MAX_LD : PROG_CYCLES;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADR_W-1:0]  addr;
        logic [MASK_W-1:0] mask;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_cnt;

    assign last_cnt = (seq_q.cnt == '0);

    always_comb begin
        seq_d     = seq_q;
        copy_o    = 1'b0;
        prog_we_o = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start_prog_i) begin
                    seq_d.state = SEQ_PROG;
                    seq_d.cnt   = CNT_W'(PROG_CYCLES - 1);
                    seq_d.addr  = prog_addr_i;
                    seq_d.mask  = prog_mask_i;
                end else if (start_load_i) begin
                    seq_d.state = SEQ_WAIT;
                    seq_d.cnt   = CNT_W'(LOAD_DELAY - 1);
                end
            end
            SEQ_WAIT: begin
                if (last_cnt) begin
                    seq_d.state = SEQ_LOAD;
                    seq_d.cnt   = CNT_W'(LOAD_CYCLES - 1);
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            SEQ_LOAD: begin
                if (last_cnt) begin
                    copy_o      = 1'b1;
                    seq_d.state = SEQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            SEQ_PROG: begin
                if (last_cnt) begin
                    prog_we_o   = 1'b1;
                    seq_d.state = SEQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_IDLE, cnt: '0, addr: '0, mask: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle_o    = (seq_q.state == SEQ_IDLE);
    assign busy_o    = (seq_q.state == SEQ_LOAD) || (seq_q.state == SEQ_PROG);
    assign we_addr_o = seq_q.addr;
    assign we_mask_o = seq_q.mask;

    AST_PROG_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog_i |-> (seq_q.state == SEQ_IDLE)); // R8
    AST_LOAD_BUSY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_load_i && !start_prog_i && seq_q.state == SEQ_IDLE) |=> !busy_o); // R3
    AST_COPY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        copy_o |=> !busy_o); // R4

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
    import otp_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 40,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADR_W     = 6,
    parameter int unsigned IDX_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we_i,
    input  logic [ADR_W-1:0]  prog_addr_i,
    input  logic [WORD_W-1:0] prog_mask_i,
    input  logic              copy_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [WORD_W-1:0] shadow_o
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] fuse;
        logic [NUM_WORDS-1:0][WORD_W-1:0] shadow;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (prog_we_i && (prog_addr_i == ADR_W'(w))) begin
                st_d.fuse[w] = st_q.fuse[w] | prog_mask_i;
            end
            if (copy_i) begin
                st_d.shadow[w] = st_q.fuse[w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        shadow_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_idx_i == IDX_W'(w)) begin
                shadow_o = st_q.shadow[w];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_mono
            AST_FUSE_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> ((st_q.fuse[g] & $past(st_q.fuse[g])) == $past(st_q.fuse[g]))); // R6
        end
    endgenerate

    AST_WRITE_ADDR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we_i |-> (prog_addr_i < ADR_W'(NUM_WORDS))); // R8
    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_i |=> $stable(st_q.shadow)); // R4

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int unsigned NUM_BANKS      = 5,
    parameter int unsigned WORDS_PER_BANK = 8,
    parameter int unsigned LOAD_DELAY     = 4,
    parameter int unsigned LOAD_CYCLES    = 40,
    parameter int unsigned PROG_CYCLES    = 200,
    parameter logic [15:0] UNLOCK_KEY     = 16'h5A3C,
    parameter int unsigned ADDR_W         = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int unsigned NUM_WORDS = NUM_BANKS * WORDS_PER_BANK;
    localparam int unsigned IDX_W     = ADDR_W - SHADOW_SHIFT;

    typedef struct packed {
        logic [FADDR_W-1:0] addr;
        logic               open;
        logic               err;
        logic [15:0]        key;
        logic [DATA_W-1:0]  data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic wr_any, wr_ctrl, wr_set, wr_clr, wr_data;
    logic key_ok, req_bad;
    logic start_load, start_prog;
    logic seq_idle, seq_busy, seq_copy, seq_we;
    logic [FADDR_W-1:0] we_addr;
    logic [DATA_W-1:0]  we_mask;
    logic [ADDR_W-1:0]  sh_off;
    logic [IDX_W-1:0]   sh_idx;
    logic               sh_hit;
    logic [DATA_W-1:0]  sh_word;
    logic [31:0]        ctl_view;

    assign wr_any  = bus_en && bus_we;
    assign wr_ctrl = wr_any && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_set  = wr_any && (bus_addr == ADDR_W'(OFS_CTRL_SET));
    assign wr_clr  = wr_any && (bus_addr == ADDR_W'(OFS_CTRL_CLR));
    assign wr_data = wr_any && (bus_addr == ADDR_W'(OFS_DATA));

    assign key_ok  = (ctl_q.key == UNLOCK_KEY);
    assign req_bad = !seq_idle || ctl_q.open || (ctl_q.addr >= FADDR_W'(NUM_WORDS));

    always_comb begin
        ctl_d      = ctl_q;
        start_prog = 1'b0;
        if (wr_ctrl) begin
            ctl_d.addr = bus_wdata[FADDR_W-1:0];
            ctl_d.open = bus_wdata[CTL_OPEN_BIT];
            ctl_d.key  = bus_wdata[CTL_KEY_LSB +: 16];
        end else if (wr_set) begin
            ctl_d.addr = ctl_q.addr | bus_wdata[FADDR_W-1:0];
            ctl_d.open = ctl_q.open | bus_wdata[CTL_OPEN_BIT];
            ctl_d.key  = ctl_q.key  | bus_wdata[CTL_KEY_LSB +: 16];
        end else if (wr_clr) begin
            ctl_d.addr = ctl_q.addr & ~bus_wdata[FADDR_W-1:0];
            ctl_d.open = ctl_q.open & ~bus_wdata[CTL_OPEN_BIT];
            ctl_d.key  = ctl_q.key  & ~bus_wdata[CTL_KEY_LSB +: 16];
            ctl_d.err  = ctl_q.err  & ~bus_wdata[CTL_ERR_BIT];
        end else if (wr_data && key_ok) begin
            ctl_d.data = bus_wdata;
            ctl_d.key  = '0;
            if (req_bad) begin
                ctl_d.err = 1'b1;
            end else begin
                start_prog = 1'b1;
            end
        end
        start_load = ctl_d.open && !ctl_q.open;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    otp_seq #(
        .LOAD_DELAY  (LOAD_DELAY),
        .LOAD_CYCLES (LOAD_CYCLES),
        .PROG_CYCLES (PROG_CYCLES),
        .MASK_W      (DATA_W),
        .ADR_W       (FADDR_W)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_load_i (start_load),
        .start_prog_i (start_prog),
        .prog_addr_i  (ctl_q.addr),
        .prog_mask_i  (bus_wdata),
        .idle_o       (seq_idle),
        .busy_o       (seq_busy),
        .copy_o       (seq_copy),
        .prog_we_o    (seq_we),
        .we_addr_o    (we_addr),
        .we_mask_o    (we_mask)
    );

    assign sh_off = bus_addr - ADDR_W'(OFS_SHADOW);
    assign sh_idx = sh_off[ADDR_W-1:SHADOW_SHIFT];
    assign sh_hit = (bus_addr >= ADDR_W'(OFS_SHADOW)) && (sh_off[SHADOW_SHIFT-1:0] == '0)
                    && (sh_idx < IDX_W'(NUM_WORDS));

    otp_fuse_store #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (DATA_W),
        .ADR_W     (FADDR_W),
        .IDX_W     (IDX_W)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_we_i   (seq_we),
        .prog_addr_i (we_addr),
        .prog_mask_i (we_mask),
        .copy_i      (seq_copy),
        .rd_idx_i    (sh_idx),
        .shadow_o    (sh_word)
    );

    always_comb begin
        ctl_view                          = '0;
        ctl_view[FADDR_W-1:0]             = ctl_q.addr;
        ctl_view[CTL_BUSY_BIT]            = seq_busy;
        ctl_view[CTL_ERR_BIT]             = ctl_q.err;
        ctl_view[CTL_OPEN_BIT]            = ctl_q.open;
        ctl_view[CTL_KEY_LSB +: 16]       = ctl_q.key;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL) || bus_addr == ADDR_W'(OFS_CTRL_SET)
            || bus_addr == ADDR_W'(OFS_CTRL_CLR)) begin
            bus_rdata = ctl_view;
        end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
            bus_rdata = ctl_q.data;
        end else if (sh_hit) begin
            bus_rdata = sh_word;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.err && !(wr_clr && bus_wdata[CTL_ERR_BIT])) |=> ctl_q.err); // R9
    AST_NOKEY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !key_ok && seq_idle && !ctl_q.open) |=> !seq_busy); // R7
    AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && key_ok) |=> (ctl_q.key == '0)); // R7
    AST_BAD_REQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && key_ok && ctl_q.addr >= FADDR_W'(NUM_WORDS)) |=> (ctl_q.err && !seq_busy)); // R8

endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb_top;

    localparam int unsigned LD = 3;
    localparam int unsigned LC = 5;
    localparam int unsigned PC = 6;
    localparam logic [15:0] KEY = 16'h5A3C;
    localparam logic [9:0] A_CTRL = 10'h000, A_SET = 10'h004, A_CLR = 10'h008, A_DATA = 10'h010;
    localparam logic [31:0] B_BUSY = 32'h0000_0100, B_ERR = 32'h0000_0200, B_OPEN = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    otp_fuse_ctrl #(
        .LOAD_DELAY  (LD),
        .LOAD_CYCLES (LC),
        .PROG_CYCLES (PC)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [9:0] sh_addr(input int n);
        return 10'(32'h100 + 32'(n) * 16);
    endfunction

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic read_exp(input logic [9:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: pops one expected item per cycle, compares away from the edge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    // raise bank-open and follow BUSY cycle by cycle (R3)
    task automatic do_load(input logic [31:0] base);
        bus_write(A_SET, B_OPEN);
        for (int k = 0; k < int'(LD + LC); k++) begin
            read_exp(A_CTRL, base | B_OPEN | ((k >= int'(LD)) ? B_BUSY : 32'h0), "R3 load busy window");
        end
        read_exp(A_CTRL, base | B_OPEN, "R3 busy low after load");
    endtask

    // arm, start, and follow a program pulse (R5, R7)
    task automatic do_prog(input logic [5:0] fa, input logic [31:0] mask);
        bus_write(A_CTRL, {KEY, 10'h0, fa});
        read_exp(A_CTRL, {KEY, 10'h0, fa}, "R5 armed key visible");
        bus_write(A_DATA, mask);
        for (int k = 0; k < int'(PC); k++) begin
            read_exp(A_CTRL, {26'h0, fa} | B_BUSY, "R5 program busy window");
        end
        read_exp(A_CTRL, {26'h0, fa}, "R7 key consumed, busy low");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_exp(A_CTRL, 32'h0, "R1 ctrl after reset");
        read_exp(A_DATA, 32'h0, "R1 data after reset");
        read_exp(sh_addr(0), 32'h0, "R1 shadow0 after reset");
        read_exp(sh_addr(39), 32'h0, "R1 shadow39 after reset");

        // R2 aliases
        bus_write(A_CTRL, 32'h0000_0015);
        read_exp(A_CTRL, 32'h0000_0015, "R2 plain write");
        bus_write(A_SET, 32'h0000_0002);
        read_exp(A_SET, 32'h0000_0017, "R2 set alias ORs");
        bus_write(A_CLR, 32'h0000_0005);
        read_exp(A_CTRL, 32'h0000_0012, "R2 clear alias");
        bus_write(A_SET, B_BUSY);
        read_exp(A_CTRL, 32'h0000_0012, "R2 busy not writable");
        bus_write(A_CTRL, 32'h0);

        // R5 program word 10, shadows unchanged before load (R4)
        do_prog(6'd10, 32'h0000_00F0);
        read_exp(sh_addr(10), 32'h0, "R4 shadow unchanged before load");
        do_load(32'h0000_000A);
        read_exp(sh_addr(10), 32'h0000_00F0, "R4 shadow after load");
        read_exp(sh_addr(0), 32'h0, "R4 other shadow zero");
        bus_write(A_CLR, B_OPEN);
        read_exp(A_CTRL, 32'h0000_000A, "R2 open cleared");

        // R6 OR semantics, R10 last word
        do_prog(6'd10, 32'h0000_0F10);
        do_prog(6'd39, 32'h8000_0001);
        read_exp(A_DATA, 32'h8000_0001, "R7 data holds mask");
        do_load(32'h0000_0027);
        read_exp(sh_addr(10), 32'h0000_0FF0, "R6 bits only set");
        read_exp(10'h370, 32'h8000_0001, "R10 bank4 word7 at 0x370");
        read_exp(10'h380, 32'h0, "R4 beyond window reads zero");
        read_exp(10'h104, 32'h0, "R4 unaligned reads zero");
        bus_write(A_CLR, B_OPEN);

        // R7 data write without key
        bus_write(A_CTRL, 32'h1234_0003);
        bus_write(A_DATA, 32'h0000_FFFF);
        read_exp(A_CTRL, 32'h1234_0003, "R7 no key: no busy no error");
        read_exp(A_DATA, 32'h8000_0001, "R7 no key: data unchanged");

        // R8 out of range address
        bus_write(A_CTRL, {KEY, 16'h0028});
        bus_write(A_DATA, 32'h0000_0001);
        read_exp(A_CTRL, 32'h0000_0028 | B_ERR, "R8 bad address sets error");
        read_exp(A_DATA, 32'h0000_0001, "R7 keyed write stores mask");

        // R9 sticky
        bus_write(A_CTRL, 32'h0000_0028);
        read_exp(A_CTRL, 32'h0000_0028 | B_ERR, "R9 plain write keeps error");
        bus_write(A_CLR, B_ERR);
        read_exp(A_CTRL, 32'h0000_0028, "R9 clear alias clears error");
        bus_write(A_SET, B_ERR);
        read_exp(A_CTRL, 32'h0000_0028, "R9 set alias cannot set error");

        // R8 request while busy
        bus_write(A_CTRL, {KEY, 16'h0003});
        bus_write(A_DATA, 32'h0000_0011);
        bus_write(A_CTRL, {KEY, 16'h0004});
        bus_write(A_DATA, 32'h0000_0022);
        read_exp(A_CTRL, 32'h0000_0004 | B_BUSY | B_ERR, "R8 busy request rejected");
        repeat (PC) @(negedge clk);
        read_exp(A_CTRL, 32'h0000_0004 | B_ERR, "R8 after busy");
        bus_write(A_CLR, B_ERR);

        // R8 request while bank open
        do_load(32'h0000_0004);
        bus_write(A_CTRL, {KEY, 16'h1005});
        read_exp(A_CTRL, {KEY, 16'h1005}, "R3 no reload without rise");
        bus_write(A_DATA, 32'h0000_0040);
        read_exp(A_CTRL, 32'h0000_0005 | B_OPEN | B_ERR, "R8 open request rejected");
        bus_write(A_CLR, B_OPEN | B_ERR);
        read_exp(A_CTRL, 32'h0000_0005, "R9 cleared with open");

        do_load(32'h0000_0005);
        read_exp(sh_addr(3), 32'h0000_0011, "R6 accepted word 3");
        read_exp(sh_addr(4), 32'h0, "R8 busy reject left word 4");
        read_exp(sh_addr(5), 32'h0, "R8 open reject left word 5");
        read_exp(sh_addr(10), 32'h0000_0FF0, "R6 word 10 kept");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule